// File: doc/BRIEF.md
# Shared Timer Prescaler Clock Selector

This block holds one 16-bit prescaler control word and a free-running divider. From them it makes four operation-clock enable pulses, and all eight timer channels share those pulses. Each channel gives a 2-bit clock-select code and a run bit. The block sends the matching tick to every channel. Two of the four clocks are available only to channels 1 and 3. Any other channel that asks for one of those two clocks falls back to one of the first two clocks.

A write to the control word is checked one field at a time. A field takes the new value only when no running channel is using the clock that field controls. In the same write, the fields that pass the check update and the fields that fail keep their old value. One cycle after a write in which any field was held back, a status flag pulses high for one cycle.

Top module: `timer_clk_sel`

## Requirements
- R1: After reset, `rd_data` is 0x0000, `wr_blocked` is 0 and the divider count is 0. With all fields at 0, the first cycle after reset shows `ck_tick` = 4'b0011.
- R2: A write made while no channel is running stores the whole word. Bits 3:0 hold field 0, bits 7:4 field 1, bits 9:8 field 2 and bits 13:12 field 3. Bits 15:14 and 11:10 always read 0, and writes to them are ignored.
- R3: The divider count starts at 0 and increases by one every clock, wrapping modulo 2^15. For field 0 or field 1 holding value k, `ck_tick[0]` or `ck_tick[1]` is high exactly when the low k bits of the count are all ones. That gives one tick every 2^k cycles.
- R4: For field 2 or field 3 holding value k, `ck_tick[2]` or `ck_tick[3]` is high exactly when the low 2k+8 bits of the count are all ones. That gives one tick every 2^(2k+8) cycles.
- R5: On a write, a field is left unchanged when at least one running channel uses its clock. In the same write, every other field takes the new value.
- R6: A channel's select code picks a clock: 00 picks clock 0, 01 clock 1, 10 clock 2 and 11 clock 3. This applies to channels 1 and 3. Every other channel uses code 10 as clock 0 and code 11 as clock 1, both for tick routing and for write gating.
- R7: `wr_blocked` is high for exactly the one cycle after a write in which at least one field was held back. It is low at all other times.
- R8: `ch_tick[n]` equals the tick of the clock that channel n's select code picks (after the fallback in R6), whether or not the channel is running.
- R9: A stopped channel never blocks a write, whatever its select code is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| ch_run | input | 8 | Run bit of each channel |
| ch_sel | input | 16 | 2-bit clock-select code per channel; channel n uses bits 2n+1:2n |
| rd_data | output | 16 | Current control word |
| ck_tick | output | 4 | Enable pulses of the four operation clocks |
| ch_tick | output | 8 | Enable pulse routed to each channel |
| wr_blocked | output | 1 | One-cycle pulse after a write with a held-back field |

## Verification
The bench builds the block with its default parameters: eight channels, a 15-bit divider, and clocks 2 and 3 enabled only for channels 1 and 3. With these settings the longest divide ratio, 2^15, is short enough to run through a full count wrap in one run. A directed phase targets specific gating cases: a write blocked only on field 2, a fallback channel blocking field 0, and stopped channels that do not block. A random phase then mixes writes, run bits and select codes, and every cycle is compared against a model of the register and the count.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    localparam int WIDE_W   = 4;
    localparam int NARROW_W = 2;
    localparam int NUM_CLK  = 4;
    localparam int SEL_W    = $clog2(NUM_CLK);

    typedef struct packed {
        logic [NARROW_W-1:0] f3;
        logic [NARROW_W-1:0] f2;
        logic [WIDE_W-1:0]   f1;
        logic [WIDE_W-1:0]   f0;
    } presc_t;

    typedef struct packed {
        presc_t presc;
        logic   blocked;
    } reg_state_t;
endpackage

// File: rtl/tcs_route.sv
module tcs_route
    import tcs_pkg::*;
#(
    parameter int          NUM_CH   = 8,
    parameter logic [7:0]  EXT_MASK = 8'b0000_1010
) (
    input  logic [SEL_W*NUM_CH-1:0] ch_sel,
    input  logic [NUM_CLK-1:0]      ck_tick,
    output logic [SEL_W*NUM_CH-1:0] eff_sel,
    output logic [NUM_CH-1:0]       ch_tick
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [SEL_W-1:0] raw;
        assign raw = ch_sel[SEL_W*n +: SEL_W];
        if (EXT_MASK[n]) begin : g_ext
            assign eff_sel[SEL_W*n +: SEL_W] = raw;
        end else begin : g_base
            // upper clocks fold onto the lower two
            assign eff_sel[SEL_W*n +: SEL_W] = {1'b0, raw[0]};
        end
        assign ch_tick[n] = ck_tick[eff_sel[SEL_W*n +: SEL_W]];
    end
endmodule

// File: rtl/tcs_regfile.sv
module tcs_regfile
    import tcs_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [15:0]             wr_data,
    input  logic [NUM_CH-1:0]       ch_run,
    input  logic [SEL_W*NUM_CH-1:0] eff_sel,
    output presc_t                  presc,
    output logic                    wr_blocked
);
    reg_state_t st_d, st_q;
    logic [NUM_CLK-1:0] field_ok;

    for (genvar f = 0; f < NUM_CLK; f++) begin : g_gate
        logic [NUM_CH-1:0] users;
        for (genvar n = 0; n < NUM_CH; n++) begin : g_user
            assign users[n] = ch_run[n] && (eff_sel[SEL_W*n +: SEL_W] == SEL_W'(f));
        end
        assign field_ok[f] = ~|users;
    end

    always_comb begin
        st_d         = st_q;
        st_d.blocked = 1'b0;
        if (wr_en) begin
            if (field_ok[0]) st_d.presc.f0 = wr_data[3:0];
            if (field_ok[1]) st_d.presc.f1 = wr_data[7:4];
            if (field_ok[2]) st_d.presc.f2 = wr_data[9:8];
            if (field_ok[3]) st_d.presc.f3 = wr_data[13:12];
            st_d.blocked = ~&field_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign presc      = st_q.presc;
    assign wr_blocked = st_q.blocked;

    // A field held back by a running user keeps its value
    assert_hold_f0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !field_ok[0]) |=> $stable(presc.f0));
    assert_hold_f2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !field_ok[2]) |=> $stable(presc.f2));
    // The status pulse only ever follows a write
    assert_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> $past(wr_en));
    assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_blocked && !$past(wr_en, 2)) |=> !wr_blocked || $past(wr_en));
endmodule

// File: rtl/tcs_divider.sv
module tcs_divider
    import tcs_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  presc_t             presc,
    output logic [NUM_CLK-1:0] ck_tick,
    output logic [CNT_W-1:0]   count
);
    localparam int NARROW_BASE = 8;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] mask [NUM_CLK];
    logic [CNT_W-1:0] one;

    assign one = CNT_W'(1);

    always_comb begin
        cnt_d   = cnt_q + one;
        mask[0] = (one << presc.f0) - one;
        mask[1] = (one << presc.f1) - one;
        mask[2] = (one << (2 * presc.f2 + NARROW_BASE)) - one;
        mask[3] = (one << (2 * presc.f3 + NARROW_BASE)) - one;
    end

    for (genvar c = 0; c < NUM_CLK; c++) begin : g_tick
        assign ck_tick[c] = &(cnt_q | ~mask[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // The slower clocks never tick unless the low 8 count bits are all ones
    assert_slow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ck_tick[2] |-> (&count[NARROW_BASE-1:0]));
    assert_slow3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ck_tick[3] |-> (&count[NARROW_BASE-1:0]));
    // An odd count with field 0 at zero still ticks; an even count never ticks unless k is 0
    assert_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_tick[0] && !count[0]) |-> (presc.f0 == '0));
endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel
    import tcs_pkg::*;
#(
    parameter int         NUM_CH   = 8,
    parameter int         CNT_W    = 15,
    parameter logic [7:0] EXT_MASK = 8'b0000_1010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         wr_data,
    input  logic [NUM_CH-1:0]   ch_run,
    input  logic [2*NUM_CH-1:0] ch_sel,
    output logic [15:0]         rd_data,
    output logic [NUM_CLK-1:0]  ck_tick,
    output logic [NUM_CH-1:0]   ch_tick,
    output logic                wr_blocked
);
    presc_t                  presc;
    logic [SEL_W*NUM_CH-1:0] eff_sel;
    logic [CNT_W-1:0]        count;

    tcs_route #(.NUM_CH(NUM_CH), .EXT_MASK(EXT_MASK)) u_route (
        .ch_sel (ch_sel),
        .ck_tick(ck_tick),
        .eff_sel(eff_sel),
        .ch_tick(ch_tick)
    );

    tcs_regfile #(.NUM_CH(NUM_CH)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ch_run    (ch_run),
        .eff_sel   (eff_sel),
        .presc     (presc),
        .wr_blocked(wr_blocked)
    );

    tcs_divider #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .presc  (presc),
        .ck_tick(ck_tick),
        .count  (count)
    );

    assign rd_data = {2'b00, presc.f3, 2'b00, presc.f2, presc.f1, presc.f0};

    // Channels without the upper clocks only ever see clock 0 or clock 1
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        if (!EXT_MASK[n]) begin : g_base
            assert_fold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ch_tick[n] |-> (ck_tick[0] || ck_tick[1]));
        end
    end
endmodule

// File: tb/timer_clk_sel_test.sv
module timer_clk_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  ch_run = '0;
    logic [15:0] ch_sel = '0;
    logic [15:0] rd_data;
    logic [3:0]  ck_tick;
    logic [7:0]  ch_tick;
    logic        wr_blocked;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state
    int          m_f [4];
    bit          m_blk;
    logic [14:0] m_cnt;
    logic [15:0] m_sel;

    always #10 clk = ~clk;

    timer_clk_sel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ch_run(ch_run), .ch_sel(ch_sel), .rd_data(rd_data),
        .ck_tick(ck_tick), .ch_tick(ch_tick), .wr_blocked(wr_blocked)
    );

    function automatic bit exp_tick(int c, int f);
        int k = (c < 2) ? f : 2 * f + 8;
        int period = 1 << k;
        return (int'(m_cnt) % period) == (period - 1);
    endfunction

    function automatic int eff(int n, logic [15:0] sel);
        int code = int'(sel[2*n +: 2]);
        if (n == 1 || n == 3) return code;
        return code & 1;
    endfunction

    function automatic logic [15:0] exp_rd();
        return {2'b00, 2'(m_f[3]), 2'b00, 2'(m_f[2]), 4'(m_f[1]), 4'(m_f[0])};
    endfunction

    task automatic check_all(input string tag);
        logic [3:0] ek;
        logic [7:0] ec;
        for (int c = 0; c < 4; c++) ek[c] = exp_tick(c, m_f[c]);
        for (int n = 0; n < 8; n++) ec[n] = ek[eff(n, m_sel)];
        vectors++;
        if (rd_data !== exp_rd()) begin
            miscompares++;
            $display("FAIL %s/R2/R5 rd_data got %h exp %h", tag, rd_data, exp_rd());
        end
        if (ck_tick[1:0] !== ek[1:0]) begin
            miscompares++;
            $display("FAIL %s/R3 ck_tick[1:0] got %b exp %b", tag, ck_tick[1:0], ek[1:0]);
        end
        if (ck_tick[3:2] !== ek[3:2]) begin
            miscompares++;
            $display("FAIL %s/R4 ck_tick[3:2] got %b exp %b", tag, ck_tick[3:2], ek[3:2]);
        end
        if (ch_tick !== ec) begin
            miscompares++;
            $display("FAIL %s/R6/R8 ch_tick got %b exp %b", tag, ch_tick, ec);
        end
        if (wr_blocked !== m_blk) begin
            miscompares++;
            $display("FAIL %s/R7 wr_blocked got %b exp %b", tag, wr_blocked, m_blk);
        end
    endtask

    // check the present cycle, then drive the next inputs and advance the model
    task automatic step(input string tag, input bit w, input logic [15:0] d,
                        input logic [7:0] run, input logic [15:0] sel);
        bit ok [4];
        bit any_bad;
        check_all(tag);
        wr_en = w; wr_data = d; ch_run = run; ch_sel = sel;
        for (int f = 0; f < 4; f++) begin
            ok[f] = 1'b1;
            for (int n = 0; n < 8; n++)
                if (run[n] && eff(n, sel) == f) ok[f] = 1'b0;   // R9: stopped never block
        end
        any_bad = 1'b0;
        if (w) begin
            if (ok[0]) m_f[0] = int'(d[3:0]);
            if (ok[1]) m_f[1] = int'(d[7:4]);
            if (ok[2]) m_f[2] = int'(d[9:8]);
            if (ok[3]) m_f[3] = int'(d[13:12]);
            for (int f = 0; f < 4; f++) if (!ok[f]) any_bad = 1'b1;
        end
        m_blk = any_bad;
        m_cnt = m_cnt + 15'd1;
        m_sel = sel;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        for (int f = 0; f < 4; f++) m_f[f] = 0;
        m_blk = 1'b0; m_cnt = '0; m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, ck_tick expected 4'b0011
        if (ck_tick !== 4'b0011) begin
            miscompares++;
            $display("FAIL R1 ck_tick got %b exp %b", ck_tick, 4'b0011);
        end
        vectors++;
        // R2: full write with nothing running, undefined bits dropped
        step("R1", 1'b1, 16'hFFFF, 8'h00, 16'h0000);
        step("R2", 1'b0, 16'h0000, 8'h00, 16'h0000);
        // R5: channel 1 running on clock 2 holds only field 2
        step("R5", 1'b1, 16'h0000, 8'h02, 16'h0008);
        step("R5", 1'b0, 16'h0000, 8'h02, 16'h0008);
        step("R7", 1'b0, 16'h0000, 8'h00, 16'h0008);
        // R6: channel 0 with code 10 falls back to clock 0 and blocks field 0
        step("R6", 1'b1, 16'h1234, 8'h01, 16'h0002);
        step("R6", 1'b0, 16'h0000, 8'h01, 16'h0002);
        // R6: channel 2 with code 11 blocks field 1, not field 3
        step("R6", 1'b1, 16'h3355, 8'h04, 16'h0030);
        step("R6", 1'b0, 16'h0000, 8'h04, 16'h0030);
        // R9: every select code but nobody running, write goes through
        step("R9", 1'b1, 16'h2176, 8'h00, 16'hFFFF);
        step("R9", 1'b0, 16'h0000, 8'h00, 16'hFFFF);
        // R7: back-to-back blocked writes
        step("R7", 1'b1, 16'h0000, 8'hFF, 16'h0000);
        step("R7", 1'b1, 16'h0000, 8'hFF, 16'h0000);
        step("R7", 1'b0, 16'h0000, 8'h00, 16'h0000);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom % 6) == 0;
            step("RND", w, 16'($urandom), 8'($urandom & $urandom & $urandom),
                 16'($urandom));
        end
        // R3/R4: slowest ratios, long enough to wrap the count
        step("R3", 1'b1, 16'h300F, 8'h00, 16'h0000);
        for (int i = 0; i < 34000; i++)
            step("R3", 1'b0, 16'($urandom), 8'($urandom), 16'($urandom));
        step("R4", 1'b1, 16'h02E0, 8'h00, 16'h00C4);
        for (int i = 0; i < 1200; i++)
            step("R4", 1'b0, 16'h0000, 8'h00, 16'($urandom));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule